// File: doc/BRIEF.md
# Fractional clock-enable divider

This block turns a stream of clock-enable ticks into a slower stream of output ticks. The average rate follows a two-stage ratio. The first stage is a pre-divider that works in half steps. The incoming tick stream runs at twice the nominal source rate, so a pre-divide field `h` gives one pulse every `h + 1` ticks. That is a rate of `2 * Fsrc / (h + 1)`. A field of zero means bypass, which is one pulse per nominal source period.

The second stage is an optional M/N fraction. An accumulator adds M on each pre-divided pulse. It emits a tick and subtracts N each time the sum reaches N. The denominator and the duty threshold arrive in complemented form, as a configuration block stores them, and the block decodes them. In dual-edge mode a phase counter runs over the pre-divided pulses modulo N. A duty output stays high while that phase is below the decoded D.

A configuration is captured on a one-cycle load strobe. The same strobe clears every counter.

Top module: `fdiv_top`

## Requirements
- R1: While reset is asserted and right after it is released, `tick_out` and `duty_out` are low. Reset loads mode 0 and pre-divide field 0.
- R2: With pre-divide field 0 (bypass), `tick_out` pulses once for every two `tick_in` pulses. Cycles without `tick_in` do not advance the count.
- R3: With pre-divide field h ≥ 1, `tick_out` pulses once for every h + 1 `tick_in` pulses. A field of 1 behaves like bypass.
- R4: `tick_out` is registered. It is high for exactly the one cycle after the `tick_in` cycle that completes a division step. It is never high without a `tick_in` in the previous cycle.
- R5: The mode field is 2 bits: 0 = pre-divide only, 1 and 3 = fractional, 2 = fractional with dual-edge duty. In a fractional mode with decoded N ≠ 0, each pre-divided pulse adds M to an accumulator that starts at 0. The pulse produces a `tick_out` exactly when the sum is ≥ N, and N is then subtracted.
- R6: Decoded N = (bitwise NOT of `cfg_n_inv`) + `cfg_m`. Decoded D = bitwise NOT of `cfg_d_inv`.
- R7: With mode 0, or with decoded N equal to 0, only the pre-divider acts and M is ignored.
- R8: When M ≥ decoded N in a fractional mode, every pre-divided pulse produces a `tick_out`.
- R9: In mode 2 the phase counter advances on each pre-divided pulse and wraps at decoded N. `duty_out` is high while the phase is below decoded D. In every other mode `duty_out` stays low.
- R10: A `cfg_load` cycle captures all configuration fields and clears the pre-divide counter, the accumulator, the phase and `tick_out`. A `tick_in` in that same cycle is ignored.
- R11: All M, N and D arithmetic wraps modulo 2^MND_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe: capture configuration and clear counters |
| cfg_prediv | input | HID_W | Half-step pre-divide field h (0 = bypass) |
| cfg_mode | input | 2 | Mode: 0 pre-divide only, 1/3 fractional, 2 fractional with duty |
| cfg_m | input | MND_W | Numerator M |
| cfg_n_inv | input | MND_W | Complement of (N − M) |
| cfg_d_inv | input | MND_W | Complement of D |
| tick_in | input | 1 | Input enable at twice the nominal source rate |
| tick_out | output | 1 | Divided output enable pulse |
| duty_out | output | 1 | Duty indication in dual-edge mode |

## Verification
The bench builds the block with HID_W = 5, MND_W = 8 and the fractional stage present. This puts the widest pre-divide field (31) within reach, along with denominators near 255. It also brings in encodings of N − M that wrap past 2^8 during decode. Ratios are measured by counting output ticks over whole accumulator periods. Runs that stop and restart partway through a period show that a load clears the counter, the accumulator and the phase.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic [1:0] {
        FD_MODE_PREDIV = 2'd0,
        FD_MODE_FRAC   = 2'd1,
        FD_MODE_DUAL   = 2'd2,
        FD_MODE_FRAC_B = 2'd3
    } fd_mode_e;

    function automatic logic fd_mode_is_frac(fd_mode_e m);
        return m != FD_MODE_PREDIV;
    endfunction

endpackage

// File: rtl/fdiv_cfg.sv
module fdiv_cfg
    import fdiv_pkg::*;
#(
    parameter int HID_W  = 5,
    parameter int MND_W  = 8,
    parameter bit MND_EN = 1'b1,
    localparam int LIM_W = HID_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [HID_W-1:0] prediv_i,
    input  logic [1:0]       mode_i,
    input  logic [MND_W-1:0] m_i,
    input  logic [MND_W-1:0] n_inv_i,
    input  logic [MND_W-1:0] d_inv_i,
    output logic [LIM_W-1:0] limit_o,
    output logic             frac_o,
    output logic             dual_o,
    output logic [MND_W-1:0] m_o,
    output logic [MND_W-1:0] n_o,
    output logic [MND_W-1:0] d_o
);

    typedef struct packed {
        logic [HID_W-1:0] pre;
        fd_mode_e         mode;
        logic [MND_W-1:0] m;
        logic [MND_W-1:0] n_inv;
        logic [MND_W-1:0] d_inv;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.pre   = prediv_i;
            st_d.mode  = fd_mode_e'(mode_i);
            st_d.m     = m_i;
            st_d.n_inv = n_inv_i;
            st_d.d_inv = d_inv_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pre: '0, mode: FD_MODE_PREDIV, m: '0, n_inv: '0, d_inv: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // Decode: half-step limit, complemented N and D (wrap at MND_W bits)
    logic [MND_W-1:0] n_dec;
    always_comb begin
        n_dec   = (~st_q.n_inv) + st_q.m;
        n_o     = n_dec;
        d_o     = ~st_q.d_inv;
        m_o     = st_q.m;
        limit_o = (st_q.pre == '0) ? LIM_W'(2) : (LIM_W'(st_q.pre) + LIM_W'(1));
        frac_o  = MND_EN && fd_mode_is_frac(st_q.mode) && (n_dec != '0);
        dual_o  = MND_EN && (st_q.mode == FD_MODE_DUAL) && (n_dec != '0);
    end

    assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (m_o == $past(m_i)) && (d_o == ~$past(d_inv_i)));

endmodule

// File: rtl/fdiv_prediv.sv
module fdiv_prediv #(
    parameter int HID_W  = 5,
    localparam int LIM_W = HID_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             pulse_o
);

    typedef struct packed {
        logic [LIM_W-1:0] cnt;
    } pd_t;

    pd_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        pulse_o = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == limit_i - LIM_W'(1)) begin
                pulse_o  = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + LIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < limit_i);

endmodule

// File: rtl/fdiv_mn.sv
module fdiv_mn #(
    parameter int MND_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             active_i,
    input  logic [MND_W-1:0] m_i,
    input  logic [MND_W-1:0] n_i,
    output logic             hit_o,
    output logic [MND_W-1:0] phase_o
);

    typedef struct packed {
        logic [MND_W-1:0] acc;
        logic [MND_W-1:0] phase;
    } mn_t;

    mn_t st_d, st_q;
    logic [MND_W:0] sum, nx, ph1;

    always_comb begin
        st_d  = st_q;
        hit_o = 1'b0;
        sum   = {1'b0, st_q.acc} + {1'b0, m_i};
        nx    = {1'b0, n_i};
        ph1   = {1'b0, st_q.phase} + (MND_W+1)'(1);
        if (clear_i || !active_i) begin
            st_d = '0;
        end else if (step_i) begin
            if (m_i >= n_i) begin
                hit_o    = 1'b1;
            end else if (sum >= nx) begin
                hit_o    = 1'b1;
                st_d.acc = MND_W'(sum - nx);
            end else begin
                st_d.acc = MND_W'(sum);
            end
            st_d.phase = (ph1 == nx) ? '0 : MND_W'(ph1);
        end
        phase_o = st_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_acc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (st_q.acc < n_i));

    assert_phase_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (st_q.phase < n_i));

endmodule

// File: rtl/fdiv_top.sv
module fdiv_top #(
    parameter int HID_W  = 5,
    parameter int MND_W  = 8,
    parameter bit MND_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [HID_W-1:0] cfg_prediv,
    input  logic [1:0]       cfg_mode,
    input  logic [MND_W-1:0] cfg_m,
    input  logic [MND_W-1:0] cfg_n_inv,
    input  logic [MND_W-1:0] cfg_d_inv,
    input  logic             tick_in,
    output logic             tick_out,
    output logic             duty_out
);

    localparam int LIM_W = HID_W + 1;

    logic [LIM_W-1:0] limit;
    logic             frac, dual;
    logic [MND_W-1:0] m_val, n_val, d_val, phase;
    logic             pd_pulse, mn_hit;

    fdiv_cfg #(.HID_W(HID_W), .MND_W(MND_W), .MND_EN(MND_EN)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cfg_load),
        .prediv_i (cfg_prediv),
        .mode_i   (cfg_mode),
        .m_i      (cfg_m),
        .n_inv_i  (cfg_n_inv),
        .d_inv_i  (cfg_d_inv),
        .limit_o  (limit),
        .frac_o   (frac),
        .dual_o   (dual),
        .m_o      (m_val),
        .n_o      (n_val),
        .d_o      (d_val)
    );

    fdiv_prediv #(.HID_W(HID_W)) u_pd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cfg_load),
        .tick_i  (tick_in),
        .limit_i (limit),
        .pulse_o (pd_pulse)
    );

    generate
        if (MND_EN) begin : g_mn
            fdiv_mn #(.MND_W(MND_W)) u_mn (
                .clk      (clk),
                .rst_n    (rst_n),
                .clear_i  (cfg_load),
                .step_i   (pd_pulse),
                .active_i (frac),
                .m_i      (m_val),
                .n_i      (n_val),
                .hit_o    (mn_hit),
                .phase_o  (phase)
            );
        end else begin : g_no_mn
            assign mn_hit = pd_pulse;
            assign phase  = '0;
        end
    endgenerate

    typedef struct packed {
        logic tick;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.tick = 1'b0;
        end else begin
            st_d.tick = frac ? mn_hit : pd_pulse;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_out = st_q.tick;
    assign duty_out = dual && (phase < d_val);

    assert_out_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> ($past(tick_in) && !$past(cfg_load)));

    assert_duty_moves_on_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_out) |-> $past(pd_pulse || cfg_load));

endmodule

// File: tb/sim_fdiv_top.sv
`timescale 1ns/1ps
module sim_fdiv_top;

    localparam int HID_W = 5;
    localparam int MND_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_load = 1'b0;
    logic [HID_W-1:0] cfg_prediv = '0;
    logic [1:0]       cfg_mode = '0;
    logic [MND_W-1:0] cfg_m = '0;
    logic [MND_W-1:0] cfg_n_inv = '0;
    logic [MND_W-1:0] cfg_d_inv = '0;
    logic             tick_in = 1'b0;
    logic             tick_out, duty_out;

    int checks = 0;
    int failures = 0;
    int outs, duties;

    always #2.5 clk = ~clk;

    fdiv_top #(.HID_W(HID_W), .MND_W(MND_W), .MND_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_prediv(cfg_prediv),
        .cfg_mode(cfg_mode), .cfg_m(cfg_m), .cfg_n_inv(cfg_n_inv),
        .cfg_d_inv(cfg_d_inv), .tick_in(tick_in), .tick_out(tick_out),
        .duty_out(duty_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Encode (M, N, D) the way the configuration inputs expect them
    task automatic load(input int h, input int mode, input int m, input int n, input int d);
        @(negedge clk);
        cfg_load   = 1'b1;
        tick_in    = 1'b1;
        cfg_prediv = HID_W'(h);
        cfg_mode   = 2'(mode);
        cfg_m      = MND_W'(m);
        cfg_n_inv  = ~MND_W'(n - m);
        cfg_d_inv  = ~MND_W'(d);
        @(negedge clk);
        cfg_load   = 1'b0;
        tick_in    = 1'b0;
    endtask

    task automatic run(input int n, input bit gappy);
        outs = 0;
        duties = 0;
        for (int i = 0; i < n; i++) begin
            outs   += int'(tick_out);
            duties += int'(duty_out);
            tick_in = gappy ? (i % 2 == 0) : 1'b1;
            @(negedge clk);
        end
        tick_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            outs += int'(tick_out);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 tick_out after reset", int'(tick_out), 0);
        check("R1 duty_out after reset", int'(duty_out), 0);
        run(8, 1'b0);
        check("R1 reset config is bypass", outs, 4);
    endtask

    task automatic t_bypass();
        load(0, 0, 0, 0, 0);
        run(40, 1'b0);
        check("R2 bypass rate", outs, 20);
        load(0, 0, 0, 0, 0);
        run(80, 1'b1);
        check("R2 gappy ticks", outs, 20);
    endtask

    task automatic t_prediv();
        load(1, 0, 0, 0, 0);
        run(40, 1'b0);
        check("R3 h=1", outs, 20);
        load(4, 0, 0, 0, 0);
        run(50, 1'b0);
        check("R3 h=4", outs, 10);
        load(31, 0, 0, 0, 0);
        run(64, 1'b0);
        check("R3 h=31", outs, 2);
    endtask

    task automatic t_latency();
        load(0, 0, 0, 0, 0);
        tick_in = 1'b1;
        @(negedge clk);
        check("R4 no out after first tick", int'(tick_out), 0);
        @(negedge clk);
        tick_in = 1'b0;
        check("R4 out one cycle after step", int'(tick_out), 1);
        @(negedge clk);
        check("R4 out single cycle", int'(tick_out), 0);
    endtask

    task automatic t_frac();
        load(0, 1, 3, 8, 0);
        run(80, 1'b0);
        check("R5 3/8 bypass", outs, 15);
        load(2, 3, 3, 8, 0);
        run(72, 1'b0);
        check("R5 3/8 after h=2", outs, 9);
        load(0, 2, 5, 12, 9);
        run(48, 1'b0);
        check("R6 5/12 decode", outs, 10);
        check("R6 duty D=9 of 12", duties, 36);
    endtask

    task automatic t_prediv_only();
        load(0, 0, 3, 8, 0);
        run(80, 1'b0);
        check("R7 mode 0 ignores M", outs, 40);
        load(0, 1, 3, 0, 0);
        run(80, 1'b0);
        check("R7 N=0 ignores M", outs, 40);
    endtask

    task automatic t_pass();
        load(0, 1, 5, 5, 0);
        run(20, 1'b0);
        check("R8 M equal N", outs, 10);
        load(0, 1, 7, 5, 0);
        run(20, 1'b0);
        check("R8 M above N", outs, 10);
    endtask

    task automatic t_duty();
        load(0, 2, 1, 4, 2);
        run(32, 1'b0);
        check("R9 dual duty count", duties, 16);
        check("R9 dual out count", outs, 4);
        load(0, 1, 1, 4, 2);
        run(32, 1'b0);
        check("R9 single-edge duty low", duties, 0);
        check("R9 single-edge outs", outs, 4);
    endtask

    task automatic t_reload();
        load(4, 0, 0, 0, 0);
        run(3, 1'b0);
        load(4, 0, 0, 0, 0);
        run(4, 1'b0);
        check("R10 prediv cleared", outs, 0);
        run(1, 1'b0);
        check("R10 first out after reload", outs, 1);
        load(0, 1, 3, 8, 0);
        run(4, 1'b0);
        check("R10 partial accumulation", outs, 0);
        load(0, 1, 3, 8, 0);
        run(4, 1'b0);
        check("R10 accumulator cleared", outs, 0);
        run(2, 1'b0);
        check("R10 hit on third step", outs, 1);
    endtask

    task automatic t_mask();
        load(0, 1, 200, 250, 0);
        run(500, 1'b0);
        check("R11 200/250 wrap decode", outs, 200);
        load(0, 2, 1, 4, 256);
        run(32, 1'b0);
        check("R11 D wraps to 0", duties, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 tick_out in reset", int'(tick_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_prediv();
        t_latency();
        t_frac();
        t_prediv_only();
        t_pass();
        t_duty();
        t_reload();
        t_mask();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule